// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block takes one 32-bit floating-point instruction word and turns it into a decoded bundle. The bundle gives the functional unit kind, the operand-form class, the precision, the selecting opcode value, and the register, displacement and immediate fields that the form uses. It also carries three flags: an illegal-encoding flag, a record flag that tells the consumer to copy status into condition field 1, and an update-writeback request for base-register update forms. It computes no effective address and does no arithmetic. A pipeline places it between instruction fetch and the floating-point issue logic.

The primary opcode at bits 31:26 splits the space into memory forms with a displacement, indexed memory forms (primary 31), single-precision arithmetic (primary 59), and double-precision arithmetic plus control (primary 63). Under primary 63, instruction bit 5 picks one of two minor opcodes: a short 5-bit minor at bits 5:1 or a long 10-bit minor at bits 10:1. Each of the two maps to its own operand-extraction classes. When parameter `OUT_REG` is 1 (the default), the result is registered one cycle behind a valid strobe.

Top module: `fpdec_top`

## Requirements
- R1: Primaries 48 to 55 are displacement memory ops. 48 to 51 give kind load (1) and 52 to 55 give kind store (2). Even primaries give form 4 (plain) and odd primaries give form 5 (update). Primaries 48, 49, 52 and 53 set single. opSel is the primary value.
- R2: Primary 31 decodes the 10-bit minor at bits 10:1. Loads (kind 1) are 535, 567, 599 and 631. Stores (kind 2) are 663, 695, 727, 759 and 983. 567, 631, 695 and 759 give form 7 (indexed update) and the others give form 6. Single is set for 535, 567, 663 and 695. opSel is the minor value.
- R3: Primary 59 decodes the 5-bit minor at bits 5:1 as kind arith (3) with single set. 18, 20, 21, 22 and 24 give form 1 (D, A, B). 25 gives form 2 (D, A, C). 28 to 31 give form 3 (D, A, B, C). opSel is the minor value.
- R4: Primary 63 with bit 5 set decodes the 5-bit minor as kind arith with single clear. 18, 20, 21, 22 and 26 give form 1. 25 gives form 2. 23 and 28 to 31 give form 3. 24 is illegal.
- R5: Primary 63 with bit 5 clear decodes the 10-bit minor. 0 and 32 give kind compare (4), form 8. 12, 14 and 15 give kind arith, form 13. 40, 72, 136 and 264 give kind move (5), form 13. 38 and 70 give kind status (6), form 10. 64 gives status, form 9. 134 gives status, form 11. 583 gives status, form 14. 711 gives status, form 12.
- R6: The register fields are D at bits 25:21, A at 20:16, B at 15:11 and C at 10:6. The form selects which fields are driven and every other field output reads 0. D is used by forms 1 to 7, 10, 13 and 14. A is used by forms 1 to 8. B is used by forms 1, 3, 6, 7, 8, 12 and 13. C is used by forms 2 and 3.
- R7: In forms 4 and 5, disp is bits 15:0 sign-extended to DISP_W bits. In forms 8, 9 and 11, crDst is bits 25:23. In form 9, crSrc is bits 20:18. In form 11, immNib is bits 15:12. In form 12, fieldMask is bits 24:17. Each of these reads 0 in any other form.
- R8: recordBit equals instruction bit 0 for legal primary 59 and 63 instructions, and is 0 for all memory forms.
- R9: Any primary or minor opcode not listed in R1 to R5 sets illegal. When illegal is set, kind, form, single, opSel, every field, recordBit and updateReq are all 0.
- R10: An update form (5 or 7) whose A field is 0 is illegal. A legal update form sets updateReq. Plain forms accept A equal to 0 as a zero base.
- R11: With OUT_REG=1, a word sampled with inValid high appears on the outputs one clock later with outValid high. After a clock with inValid low, outValid is low and the outputs hold their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Instruction word valid strobe |
| insn | input | 32 | Instruction word |
| outValid | output | 1 | Decoded bundle valid |
| unitKind | output | 3 | 0 none, 1 load, 2 store, 3 arith, 4 compare, 5 move, 6 status |
| formCls | output | 4 | Operand-form class (see R1 to R5) |
| singlePrec | output | 1 | Single-precision operation |
| opSel | output | 10 | Primary or minor opcode that selected the operation |
| regD | output | 5 | Target / bit-number field |
| regA | output | 5 | First source / base field |
| regB | output | 5 | Second source / index field |
| regC | output | 5 | Third source field |
| disp | output | DISP_W | Sign-extended displacement |
| crDst | output | 3 | Destination condition field |
| crSrc | output | 3 | Source status field |
| immNib | output | 4 | 4-bit immediate |
| fieldMask | output | 8 | Status field-write mask |
| illegal | output | 1 | Illegal encoding |
| recordBit | output | 1 | Copy status into condition field 1 |
| updateReq | output | 1 | Write effective address back to base register |

## Verification
All 64 primary opcodes are swept with varied filler bits, which separates the memory, indexed, short-minor and long-minor paths from the illegal primaries. Every 10-bit minor is tried under primaries 31 and 63. Under 63 this exercises the bit-5 split, since a long code whose bit 4 is set must fall to the short table. Every 5-bit minor is tried under 59 and 63, so the values that are legal under one primary and illegal under the other are told apart. Further words force A to 0 on update and plain forms, put the displacement sign bit at both values, and set bit 0 on memory and arithmetic words. Idle cycles placed between words confirm that the outputs hold.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int INSN_W  = 32;
  localparam int RIDX_W  = 5;
  localparam int SEL_W   = 10;

  // primary opcodes
  localparam logic [5:0] PRI_INDEXED = 6'd31;
  localparam logic [5:0] PRI_SINGLE  = 6'd59;
  localparam logic [5:0] PRI_DOUBLE  = 6'd63;
  localparam logic [5:0] PRI_MEM_LO  = 6'd48;
  localparam logic [5:0] PRI_MEM_HI  = 6'd55;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_LOAD    = 3'd1,
    KIND_STORE   = 3'd2,
    KIND_ARITH   = 3'd3,
    KIND_COMPARE = 3'd4,
    KIND_MOVE    = 3'd5,
    KIND_STATUS  = 3'd6
  } unitKind_e;

  typedef enum logic [3:0] {
    FORM_NONE     = 4'd0,
    FORM_TWO_SRC  = 4'd1,
    FORM_MUL      = 4'd2,
    FORM_FUSED    = 4'd3,
    FORM_DISP     = 4'd4,
    FORM_DISP_UPD = 4'd5,
    FORM_IDX      = 4'd6,
    FORM_IDX_UPD  = 4'd7,
    FORM_CMP      = 4'd8,
    FORM_CR_MOVE  = 4'd9,
    FORM_BIT      = 4'd10,
    FORM_IMM      = 4'd11,
    FORM_MASK     = 4'd12,
    FORM_UNARY    = 4'd13,
    FORM_DEST     = 4'd14
  } formCls_e;

  // strobes from control to datapath: which fields to drive
  typedef struct packed {
    logic useD;
    logic useA;
    logic useB;
    logic useC;
    logic useDisp;
    logic useCrDst;
    logic useCrSrc;
    logic useImm;
    logic useMask;
  } fieldStrobe_t;

  typedef struct packed {
    unitKind_e        kind;
    formCls_e         form;
    logic             single;
    logic [SEL_W-1:0] opSel;
    logic             illegal;
    logic             record;
    logic             update;
  } classResult_t;

endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output classResult_t      cls,
  output fieldStrobe_t      strobe
);

  logic [5:0]       primary;
  logic [4:0]       shortMinor;
  logic [9:0]       longMinor;
  logic [4:0]       baseField;

  unitKind_e        rawKind;
  formCls_e         rawForm;
  logic             rawSingle;
  logic [SEL_W-1:0] rawSel;
  logic             known;
  logic             isUpdate;
  logic             badBase;
  logic             isIllegal;
  logic             arithPrimary;

  assign primary      = insn[31:26];
  assign shortMinor   = insn[5:1];
  assign longMinor    = insn[10:1];
  assign baseField    = insn[20:16];
  assign arithPrimary = (primary == PRI_SINGLE) || (primary == PRI_DOUBLE);

  // classification of short-minor arithmetic codes shared by 59 and 63
  function automatic formCls_e shortForm(input logic [4:0] m, input logic dbl);
    formCls_e f;
    f = FORM_NONE;
    case (m)
      5'd18, 5'd20, 5'd21, 5'd22: f = FORM_TWO_SRC;
      5'd24:                      f = dbl ? FORM_NONE : FORM_TWO_SRC;
      5'd26:                      f = dbl ? FORM_TWO_SRC : FORM_NONE;
      5'd25:                      f = FORM_MUL;
      5'd23:                      f = dbl ? FORM_FUSED : FORM_NONE;
      5'd28, 5'd29, 5'd30, 5'd31: f = FORM_FUSED;
      default:                    f = FORM_NONE;
    endcase
    return f;
  endfunction

  always_comb begin
    rawKind   = KIND_NONE;
    rawForm   = FORM_NONE;
    rawSingle = 1'b0;
    rawSel    = '0;
    known     = 1'b0;

    if (primary >= PRI_MEM_LO && primary <= PRI_MEM_HI) begin
      known     = 1'b1;
      rawKind   = primary[2] ? KIND_STORE : KIND_LOAD;
      rawForm   = primary[0] ? FORM_DISP_UPD : FORM_DISP;
      rawSingle = ~primary[1];
      rawSel    = SEL_W'(primary);
    end else if (primary == PRI_INDEXED) begin
      rawSel = longMinor;
      known  = 1'b1;
      case (longMinor)
        10'd535: begin rawKind = KIND_LOAD;  rawForm = FORM_IDX;     rawSingle = 1'b1; end
        10'd567: begin rawKind = KIND_LOAD;  rawForm = FORM_IDX_UPD; rawSingle = 1'b1; end
        10'd599: begin rawKind = KIND_LOAD;  rawForm = FORM_IDX;     end
        10'd631: begin rawKind = KIND_LOAD;  rawForm = FORM_IDX_UPD; end
        10'd663: begin rawKind = KIND_STORE; rawForm = FORM_IDX;     rawSingle = 1'b1; end
        10'd695: begin rawKind = KIND_STORE; rawForm = FORM_IDX_UPD; rawSingle = 1'b1; end
        10'd727: begin rawKind = KIND_STORE; rawForm = FORM_IDX;     end
        10'd759: begin rawKind = KIND_STORE; rawForm = FORM_IDX_UPD; end
        10'd983: begin rawKind = KIND_STORE; rawForm = FORM_IDX;     end
        default: known = 1'b0;
      endcase
    end else if (primary == PRI_SINGLE) begin
      rawForm   = shortForm(shortMinor, 1'b0);
      known     = (rawForm != FORM_NONE);
      rawKind   = KIND_ARITH;
      rawSingle = 1'b1;
      rawSel    = SEL_W'(shortMinor);
    end else if (primary == PRI_DOUBLE && insn[5]) begin
      rawForm = shortForm(shortMinor, 1'b1);
      known   = (rawForm != FORM_NONE);
      rawKind = KIND_ARITH;
      rawSel  = SEL_W'(shortMinor);
    end else if (primary == PRI_DOUBLE) begin
      rawSel = longMinor;
      known  = 1'b1;
      case (longMinor)
        10'd0, 10'd32:                  begin rawKind = KIND_COMPARE; rawForm = FORM_CMP;     end
        10'd12, 10'd14, 10'd15:         begin rawKind = KIND_ARITH;   rawForm = FORM_UNARY;   end
        10'd40, 10'd72, 10'd136,
        10'd264:                        begin rawKind = KIND_MOVE;    rawForm = FORM_UNARY;   end
        10'd38, 10'd70:                 begin rawKind = KIND_STATUS;  rawForm = FORM_BIT;     end
        10'd64:                         begin rawKind = KIND_STATUS;  rawForm = FORM_CR_MOVE; end
        10'd134:                        begin rawKind = KIND_STATUS;  rawForm = FORM_IMM;     end
        10'd583:                        begin rawKind = KIND_STATUS;  rawForm = FORM_DEST;    end
        10'd711:                        begin rawKind = KIND_STATUS;  rawForm = FORM_MASK;    end
        default: known = 1'b0;
      endcase
    end
  end

  assign isUpdate  = (rawForm == FORM_DISP_UPD) || (rawForm == FORM_IDX_UPD);
  assign badBase   = isUpdate && (baseField == '0);
  assign isIllegal = !known || badBase;

  always_comb begin
    cls = '0;
    cls.illegal = isIllegal;
    if (!isIllegal) begin
      cls.kind   = rawKind;
      cls.form   = rawForm;
      cls.single = rawSingle;
      cls.opSel  = rawSel;
      cls.record = arithPrimary && insn[0];
      cls.update = isUpdate;
    end
  end

  always_comb begin
    strobe = '0;
    case (cls.form)
      FORM_TWO_SRC:  begin strobe.useD = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; end
      FORM_MUL:      begin strobe.useD = 1'b1; strobe.useA = 1'b1; strobe.useC = 1'b1; end
      FORM_FUSED:    begin strobe.useD = 1'b1; strobe.useA = 1'b1;
                           strobe.useB = 1'b1; strobe.useC = 1'b1; end
      FORM_DISP,
      FORM_DISP_UPD: begin strobe.useD = 1'b1; strobe.useA = 1'b1; strobe.useDisp = 1'b1; end
      FORM_IDX,
      FORM_IDX_UPD:  begin strobe.useD = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; end
      FORM_CMP:      begin strobe.useCrDst = 1'b1; strobe.useA = 1'b1; strobe.useB = 1'b1; end
      FORM_CR_MOVE:  begin strobe.useCrDst = 1'b1; strobe.useCrSrc = 1'b1; end
      FORM_BIT:      strobe.useD = 1'b1;
      FORM_IMM:      begin strobe.useCrDst = 1'b1; strobe.useImm = 1'b1; end
      FORM_MASK:     begin strobe.useMask = 1'b1; strobe.useB = 1'b1; end
      FORM_UNARY:    begin strobe.useD = 1'b1; strobe.useB = 1'b1; end
      FORM_DEST:     strobe.useD = 1'b1;
      default:       strobe = '0;
    endcase
  end

endmodule

// File: rtl/fpdec_datapath.sv
module fpdec_datapath
  import fpdec_pkg::*;
#(
  parameter int DISP_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSN_W-1:0]  insn,
  input  fieldStrobe_t       strobe,
  input  classResult_t       cls,
  output logic               outValid,
  output logic [2:0]         unitKind,
  output logic [3:0]         formCls,
  output logic               singlePrec,
  output logic [SEL_W-1:0]   opSel,
  output logic [RIDX_W-1:0]  regD,
  output logic [RIDX_W-1:0]  regA,
  output logic [RIDX_W-1:0]  regB,
  output logic [RIDX_W-1:0]  regC,
  output logic [DISP_W-1:0]  disp,
  output logic [2:0]         crDst,
  output logic [2:0]         crSrc,
  output logic [3:0]         immNib,
  output logic [7:0]         fieldMask,
  output logic               illegal,
  output logic               recordBit,
  output logic               updateReq
);

  typedef struct packed {
    logic [2:0]        kind;
    logic [3:0]        form;
    logic              single;
    logic [SEL_W-1:0]  sel;
    logic [RIDX_W-1:0] d;
    logic [RIDX_W-1:0] a;
    logic [RIDX_W-1:0] b;
    logic [RIDX_W-1:0] c;
    logic [DISP_W-1:0] disp;
    logic [2:0]        crDst;
    logic [2:0]        crSrc;
    logic [3:0]        imm;
    logic [7:0]        mask;
    logic              illegal;
    logic              record;
    logic              update;
  } bundle_t;

  bundle_t nextBundle;
  bundle_t curBundle;
  logic    curValid;

  always_comb begin
    nextBundle         = '0;
    nextBundle.kind    = cls.kind;
    nextBundle.form    = cls.form;
    nextBundle.single  = cls.single;
    nextBundle.sel     = cls.opSel;
    nextBundle.illegal = cls.illegal;
    nextBundle.record  = cls.record;
    nextBundle.update  = cls.update;
    nextBundle.d       = strobe.useD     ? insn[25:21] : '0;
    nextBundle.a       = strobe.useA     ? insn[20:16] : '0;
    nextBundle.b       = strobe.useB     ? insn[15:11] : '0;
    nextBundle.c       = strobe.useC     ? insn[10:6]  : '0;
    nextBundle.disp    = strobe.useDisp  ? DISP_W'($signed(insn[15:0])) : '0;
    nextBundle.crDst   = strobe.useCrDst ? insn[25:23] : '0;
    nextBundle.crSrc   = strobe.useCrSrc ? insn[20:18] : '0;
    nextBundle.imm     = strobe.useImm   ? insn[15:12] : '0;
    nextBundle.mask    = strobe.useMask  ? insn[24:17] : '0;
  end

  generate
    if (OUT_REG) begin : g_reg
      bundle_t heldBundle;
      logic    heldValid;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          heldBundle <= '0;
          heldValid  <= 1'b0;
        end else begin
          heldValid <= inValid;
          if (inValid) heldBundle <= nextBundle;
        end
      end

      assign curBundle = heldBundle;
      assign curValid  = heldValid;

      assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> $past(inValid));
      assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
        !$past(inValid) |-> $stable(heldBundle));
      assert_update_base_R10: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && updateReq) |-> (regA != '0));
      assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && illegal) |-> (unitKind == '0 && formCls == '0 && !updateReq &&
                                   !recordBit && regD == '0 && disp == '0));
      assert_record_scope_R8: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && recordBit) |-> (unitKind != 3'd1 && unitKind != 3'd2));
    end else begin : g_comb
      assign curBundle = nextBundle;
      assign curValid  = inValid;
    end
  endgenerate

  assign outValid   = curValid;
  assign unitKind   = curBundle.kind;
  assign formCls    = curBundle.form;
  assign singlePrec = curBundle.single;
  assign opSel      = curBundle.sel;
  assign regD       = curBundle.d;
  assign regA       = curBundle.a;
  assign regB       = curBundle.b;
  assign regC       = curBundle.c;
  assign disp       = curBundle.disp;
  assign crDst      = curBundle.crDst;
  assign crSrc      = curBundle.crSrc;
  assign immNib     = curBundle.imm;
  assign fieldMask  = curBundle.mask;
  assign illegal    = curBundle.illegal;
  assign recordBit  = curBundle.record;
  assign updateReq  = curBundle.update;

endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
#(
  parameter int DISP_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       insn,
  output logic              outValid,
  output logic [2:0]        unitKind,
  output logic [3:0]        formCls,
  output logic              singlePrec,
  output logic [9:0]        opSel,
  output logic [4:0]        regD,
  output logic [4:0]        regA,
  output logic [4:0]        regB,
  output logic [4:0]        regC,
  output logic [DISP_W-1:0] disp,
  output logic [2:0]        crDst,
  output logic [2:0]        crSrc,
  output logic [3:0]        immNib,
  output logic [7:0]        fieldMask,
  output logic              illegal,
  output logic              recordBit,
  output logic              updateReq
);

  classResult_t cls;
  fieldStrobe_t strobe;

  fpdec_ctrl u_ctrl (
    .insn   (insn),
    .cls    (cls),
    .strobe (strobe)
  );

  fpdec_datapath #(
    .DISP_W  (DISP_W),
    .OUT_REG (OUT_REG)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .insn       (insn),
    .strobe     (strobe),
    .cls        (cls),
    .outValid   (outValid),
    .unitKind   (unitKind),
    .formCls    (formCls),
    .singlePrec (singlePrec),
    .opSel      (opSel),
    .regD       (regD),
    .regA       (regA),
    .regB       (regB),
    .regC       (regC),
    .disp       (disp),
    .crDst      (crDst),
    .crSrc      (crSrc),
    .immNib     (immNib),
    .fieldMask  (fieldMask),
    .illegal    (illegal),
    .recordBit  (recordBit),
    .updateReq  (updateReq)
  );

endmodule

// File: tb/fpdec_top_bench.sv
module fpdec_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W      = 91;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic        outValid;
  logic [2:0]  unitKind;
  logic [3:0]  formCls;
  logic        singlePrec;
  logic [9:0]  opSel;
  logic [4:0]  regD, regA, regB, regC;
  logic [31:0] disp;
  logic [2:0]  crDst, crSrc;
  logic [3:0]  immNib;
  logic [7:0]  fieldMask;
  logic        illegal, recordBit, updateReq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpdec_top u_fpdec_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn),
    .outValid(outValid), .unitKind(unitKind), .formCls(formCls),
    .singlePrec(singlePrec), .opSel(opSel), .regD(regD), .regA(regA),
    .regB(regB), .regC(regC), .disp(disp), .crDst(crDst), .crSrc(crSrc),
    .immNib(immNib), .fieldMask(fieldMask), .illegal(illegal),
    .recordBit(recordBit), .updateReq(updateReq)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [VEC_W-1:0] actualVec();
    return {unitKind, formCls, singlePrec, opSel, regD, regA, regB, regC,
            disp, crDst, crSrc, immNib, fieldMask, illegal, recordBit, updateReq};
  endfunction

  // reference decode written from the requirement list
  function automatic logic [VEC_W-1:0] model(input logic [31:0] w);
    logic [5:0] p;
    logic [9:0] x;
    logic [4:0] m;
    int kind, form;
    logic sgl, ok, upd, rec;
    logic [9:0] sel;
    logic [4:0] d, a, b, c;
    logic [31:0] dsp;
    logic [2:0] cd, cs;
    logic [3:0] im;
    logic [7:0] mk;
    p = w[31:26]; x = w[10:1]; m = w[5:1];
    kind = 0; form = 0; sgl = 0; ok = 0; sel = '0;
    if (p >= 48 && p <= 55) begin
      ok = 1; kind = (p < 52) ? 1 : 2; form = p[0] ? 5 : 4;
      sgl = (p == 48 || p == 49 || p == 52 || p == 53); sel = 10'(p);
    end else if (p == 31) begin
      sel = x; ok = 1;
      case (x)
        535: begin kind = 1; form = 6; sgl = 1; end
        567: begin kind = 1; form = 7; sgl = 1; end
        599: begin kind = 1; form = 6; end
        631: begin kind = 1; form = 7; end
        663: begin kind = 2; form = 6; sgl = 1; end
        695: begin kind = 2; form = 7; sgl = 1; end
        727: begin kind = 2; form = 6; end
        759: begin kind = 2; form = 7; end
        983: begin kind = 2; form = 6; end
        default: ok = 0;
      endcase
    end else if (p == 59 || (p == 63 && w[5])) begin
      kind = 3; sgl = (p == 59); sel = 10'(m); ok = 1;
      if (m == 18 || m == 20 || m == 21 || m == 22) form = 1;
      else if (m == 24 && p == 59) form = 1;
      else if (m == 26 && p == 63) form = 1;
      else if (m == 25) form = 2;
      else if (m == 23 && p == 63) form = 3;
      else if (m >= 28) form = 3;
      else ok = 0;
    end else if (p == 63) begin
      sel = x; ok = 1;
      case (x)
        0, 32:             begin kind = 4; form = 8; end
        12, 14, 15:        begin kind = 3; form = 13; end
        40, 72, 136, 264:  begin kind = 5; form = 13; end
        38, 70:            begin kind = 6; form = 10; end
        64:                begin kind = 6; form = 9; end
        134:               begin kind = 6; form = 11; end
        583:               begin kind = 6; form = 14; end
        711:               begin kind = 6; form = 12; end
        default: ok = 0;
      endcase
    end
    upd = (form == 5 || form == 7);
    if (ok && upd && w[20:16] == 0) ok = 0;
    if (!ok) return {VEC_W{1'b0}} | VEC_W'(3'b100);
    rec = (p == 59 || p == 63) && w[0];
    d  = ((form >= 1 && form <= 7) || form == 10 || form == 13 || form == 14) ? w[25:21] : '0;
    a  = (form >= 1 && form <= 8) ? w[20:16] : '0;
    b  = (form == 1 || form == 3 || form == 6 || form == 7 || form == 8 ||
          form == 12 || form == 13) ? w[15:11] : '0;
    c  = (form == 2 || form == 3) ? w[10:6] : '0;
    dsp = (form == 4 || form == 5) ? {{16{w[15]}}, w[15:0]} : '0;
    cd = (form == 8 || form == 9 || form == 11) ? w[25:23] : '0;
    cs = (form == 9) ? w[20:18] : '0;
    im = (form == 11) ? w[15:12] : '0;
    mk = (form == 12) ? w[24:17] : '0;
    return {3'(kind), 4'(form), sgl, sel, d, a, b, c, dsp, cd, cs, im, mk,
            1'b0, rec, upd};
  endfunction

  function automatic string autoTag(input logic [31:0] w);
    logic [VEC_W-1:0] e;
    e = model(w);
    if (e[2]) begin
      if ((w[31:26] >= 48 && w[31:26] <= 55) || w[31:26] == 31) begin
        if (w[20:16] == 0) return "R10";
      end
      return "R9";
    end
    if (w[31:26] == 31) return "R2";
    if (w[31:26] == 59) return "R3";
    if (w[31:26] == 63) return w[5] ? "R4" : "R5";
    return "R1";
  endfunction

  task automatic checkVec(input string tag, input logic [VEC_W-1:0] act,
                          input logic [VEC_W-1:0] exp, input logic [31:0] w);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive one word, check the registered result, optionally check the hold
  task automatic decodeOne(input logic [31:0] w, input string tag, input bit holdChk);
    @(negedge clk);
    insn = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    insn = ~w;
    checkBit("R11", outValid, 1'b1);
    checkVec(tag, actualVec(), model(w), w);
    if (holdChk) begin
      @(negedge clk);
      checkBit("R11", outValid, 1'b0);
      checkVec("R11", actualVec(), model(w), w);
    end
  endtask

  task automatic sweepWord(input logic [31:0] w, input bit holdChk);
    decodeOne(w, autoTag(w), holdChk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R11 reset state
    checkBit("R11", outValid, 1'b0);
    checkVec("R11", actualVec(), {VEC_W{1'b0}}, 32'h0);
    rstN = 1'b1;

    // every primary, random filler
    for (int p = 0; p < 64; p++) begin
      for (int k = 0; k < 4; k++) begin
        seed = nextRand(seed);
        sweepWord({6'(p), seed[25:0]}, k == 0);
      end
    end
    // all long minors under 31 and 63
    for (int x = 0; x < 1024; x++) begin
      seed = nextRand(seed); r = seed;
      sweepWord({6'd31, r[25:11], 10'(x), r[0]}, (x % 64) == 0);
      seed = nextRand(seed); r = seed;
      sweepWord({6'd63, r[25:11], 10'(x), r[0]}, 1'b0);
    end
    // all short minors under 59 and 63
    for (int m = 0; m < 32; m++) begin
      for (int k = 0; k < 2; k++) begin
        seed = nextRand(seed); r = seed;
        sweepWord({6'd59, r[25:6], 5'(m), r[0]}, 1'b0);
        seed = nextRand(seed); r = seed;
        sweepWord({6'd63, r[25:6], 5'(m), r[0]}, 1'b0);
      end
    end
    // R10: A field forced to zero on memory forms
    for (int p = 48; p <= 55; p++) begin
      seed = nextRand(seed); r = seed;
      decodeOne({6'(p), r[25:21], 5'd0, r[15:0]}, "R10", 1'b0);
    end
    decodeOne({6'd31, 5'd3, 5'd0, 5'd4, 10'd567, 1'b0}, "R10", 1'b0);
    decodeOne({6'd31, 5'd3, 5'd0, 5'd4, 10'd535, 1'b0}, "R10", 1'b0);
    decodeOne({6'd31, 5'd3, 5'd9, 5'd4, 10'd759, 1'b0}, "R10", 1'b0);
    checkBit("R10", updateReq, 1'b1);
    // R7: displacement sign at both values
    decodeOne({6'd50, 5'd1, 5'd2, 16'h8000}, "R7", 1'b0);
    checkBit("R7", disp[31], 1'b1);
    decodeOne({6'd50, 5'd1, 5'd2, 16'h7fff}, "R7", 1'b0);
    checkBit("R7", disp[31], 1'b0);
    // R6: multiply leaves B at zero although bits 15:11 are set
    decodeOne({6'd63, 5'd7, 5'd8, 5'd31, 5'd9, 5'd25, 1'b0}, "R6", 1'b0);
    checkBit("R6", regB == 5'd0, 1'b1);
    // R8: bit 0 on a load vs arithmetic
    decodeOne({6'd48, 5'd1, 5'd2, 16'h0001}, "R8", 1'b0);
    checkBit("R8", recordBit, 1'b0);
    decodeOne({6'd59, 5'd1, 5'd2, 5'd3, 5'd0, 5'd21, 1'b1}, "R8", 1'b1);
    checkBit("R8", recordBit, 1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule